// File: doc/BRIEF.md
# EEPROM Page-Write Host

This block is a bus master for a two-wire serial EEPROM. It writes a run of 1 to 64 bytes, all inside one memory page, in a single bus frame. A command gives the two strap bits of the target device, a 16-bit start address and a length field. The bytes then arrive one at a time over a valid/ready stream. The host sends a start condition, the device select byte with the write direction, the address high byte, the address low byte, every data byte and a stop condition.

After the stop the EEPROM is busy with its internal programming cycle. The host does not wait a fixed time. It keeps probing the device with a start condition and the device select byte, and it closes each probe with a stop. The first probe that the device acknowledges shows that the programming cycle has ended. The host then closes the bus and reports completion.

A refused byte during the write frame ends the transfer with an error. Too many refused probes end it with a timeout. All bus timing comes from a clock divider parameter.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `sclOut` and `sdaOut` are both 1 (bus released), `busy` is 0, `cmdReady` is 1, and `done`, `errNack` and `errTimeout` are 0.
- R2: The first byte after the start condition is the device select byte {4'b1010, 1'b0, cmdStrap[1], cmdStrap[0], 1'b0}, sent MSB first. Bit 0 is the direction bit, and 0 means write.
- R3: The device select byte is followed by cmdAddr[15:8] and then by cmdAddr[7:0], each sent MSB first.
- R4: The frame carries exactly cmdLen+1 data bytes (cmdLen is 0 to 63). They are taken from the stream in arrival order, one byte per cycle where `dataValid` and `dataReady` are both 1. `dataReady` is never 1 while `dataValid` is 0.
- R5: After the acknowledge of the last data byte, the host issues a stop condition. Every frame it opens is closed by exactly one stop condition.
- R6: After the write stop, the host sends probe frames, each a start condition plus the device select byte of R2. A refused probe is followed by a stop and a new probe. An acknowledged probe is followed by a stop, and then `done` pulses high for one cycle with the bus released.
- R7: If the device refuses the device select byte, either address byte or any data byte of the write frame, the host sends a stop, sends no probe, and pulses `errNack` for one cycle.
- R8: If POLL_LIMIT probes in a row are refused, the host sends a stop and pulses `errTimeout` for one cycle. If the device acknowledges probe number POLL_LIMIT, `done` pulses instead.
- R9: `busy` is 1 from the cycle after a command is accepted until the cycle in which `done`, `errNack` or `errTimeout` pulses. `cmdReady` is 0 whenever `busy` is 1.
- R10: `sdaOut` changes while `sclOut` is high only to form a start condition (falling) or a stop condition (rising).
- R11: During every address, data and acknowledge bit inside a frame, `sclOut` stays high for exactly 2*CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Host idle and able to accept a command |
| cmdStrap | input | 2 | Strap bits of the target device |
| cmdAddr | input | 16 | First memory address to write |
| cmdLen | input | 6 | Number of data bytes minus one |
| dataValid | input | 1 | Stream byte available |
| dataReady | output | 1 | Stream byte taken this cycle |
| dataByte | input | 8 | Stream byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: write finished and device idle |
| errNack | output | 1 | One-cycle pulse: transfer aborted on a refused byte |
| errTimeout | output | 1 | One-cycle pulse: probe limit reached |
| sclOut | output | 1 | Clock line drive (1 = release) |
| sdaOut | output | 1 | Data line drive (1 = release) |
| sdaIn | input | 1 | Sensed data line level |

## Verification
The hardest case to reach from the ports is the probe-limit boundary: the device must refuse exactly POLL_LIMIT-1 probes in one run and exactly POLL_LIMIT probes in another. The bench therefore models the EEPROM on the wires, with a busy counter that is loaded at each write stop and that refuses that many probes before it acknowledges one. Refusals during the write frame are forced by arming the model to refuse a chosen byte position, and by addressing a device whose strap bits do not match. Random lengths, addresses, busy depths and gaps in the data stream are mixed with these directed runs.

// File: rtl/epw_pkg.sv
package epw_pkg;

  // Fixed upper nibble of the device select byte
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Operations the bit engine can perform
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } op_e;

  // Strobes from control to bit engine; at most one flag set per cycle
  typedef struct packed {
    logic       start;
    logic       sendByte;
    logic       stop;
    logic [7:0] txByte;
  } strobe_t;

endpackage

// File: rtl/epw_bitpath.sv
module epw_bitpath
  import epw_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t cmd,
  input  logic    sdaIn,
  output logic    opDone,
  output logic    ackSeen,
  output logic    sclOut,
  output logic    sdaOut
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  op_e              opKind;
  logic [1:0]       quarter;
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       bitCnt;
  logic [7:0]       shiftReg;
  logic             sclQ, sdaQ;
  logic             sclNext, sdaNext, txBit, tick, launch;

  assign launch = cmd.start | cmd.sendByte | cmd.stop;
  assign tick   = active && (divCnt == DIV_LAST);
  assign txBit  = (bitCnt == 4'd8) ? 1'b1 : shiftReg[7];

  // Line levels per quarter of the current operation
  always_comb begin
    unique case (opKind)
      OP_START: begin
        sclNext = (quarter < 2'd2);
        sdaNext = (quarter == 2'd0);
      end
      OP_BYTE: begin
        sclNext = (quarter == 2'd1) || (quarter == 2'd2);
        sdaNext = txBit;
      end
      default: begin
        sclNext = (quarter != 2'd0);
        sdaNext = (quarter >= 2'd2);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      opKind   <= OP_STOP;
      quarter  <= 2'd0;
      divCnt   <= '0;
      bitCnt   <= 4'd0;
      shiftReg <= 8'd0;
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      opDone   <= 1'b0;
      ackSeen  <= 1'b0;
    end else begin
      opDone <= 1'b0;
      if (!active) begin
        if (launch) begin
          active   <= 1'b1;
          opKind   <= cmd.start ? OP_START : (cmd.sendByte ? OP_BYTE : OP_STOP);
          quarter  <= 2'd0;
          divCnt   <= '0;
          bitCnt   <= 4'd0;
          shiftReg <= cmd.txByte;
        end
      end else begin
        sclQ <= sclNext;
        sdaQ <= sdaNext;
        if (tick) begin
          divCnt  <= '0;
          quarter <= quarter + 2'd1;
          if (opKind == OP_BYTE && quarter == 2'd1 && bitCnt == 4'd8)
            ackSeen <= !sdaIn;
          if (quarter == 2'd3) begin
            if (opKind != OP_BYTE || bitCnt == 4'd8) begin
              active <= 1'b0;
              opDone <= 1'b1;
            end else begin
              bitCnt   <= bitCnt + 4'd1;
              shiftReg <= {shiftReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclOut = sclQ;
  assign sdaOut = sdaQ;

  // Data may only move under a high clock for start/stop
  assert_sda_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && $past(sclQ) && (sdaQ != $past(sdaQ))) |-> (opKind != OP_BYTE));

  // Control never launches while an operation runs
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !launch);

  // One operation kind per launch
  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.start, cmd.sendByte, cmd.stop}));

endmodule

// File: rtl/epw_control.sv
module epw_control
  import epw_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  output logic                          cmdReady,
  input  logic [1:0]                    cmdStrap,
  input  logic [15:0]                   cmdAddr,
  input  logic [$clog2(PAGE_BYTES)-1:0] cmdLen,
  input  logic                          dataValid,
  output logic                          dataReady,
  input  logic [7:0]                    dataByte,
  output logic                          busy,
  output logic                          done,
  output logic                          errNack,
  output logic                          errTimeout,
  output strobe_t                       strobe,
  input  logic                          opDone,
  input  logic                          ackSeen
);

  localparam int LEN_W = $clog2(PAGE_BYTES);
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEV, S_AHI, S_ALO, S_DATA, S_WSTOP,
    S_PSTART, S_PDEV, S_PSTOP, S_ESTOP, S_FSTOP
  } state_e;

  state_e         state;
  logic           launched;
  logic [1:0]     strapQ;
  logic [15:0]    addrQ;
  logic [LEN_W-1:0] remQ;
  logic [PW-1:0]  pollCnt;
  logic           nackFlag, toFlag;
  logic [7:0]     devByte;
  logic           launchNow;

  assign devByte   = {DEV_TYPE, 1'b0, strapQ, 1'b0};
  assign cmdReady  = (state == S_IDLE);
  assign launchNow = strobe.start | strobe.sendByte | strobe.stop;

  always_comb begin
    strobe    = '0;
    dataReady = 1'b0;
    if (!launched) begin
      case (state)
        S_START, S_PSTART: strobe.start = 1'b1;
        S_DEV, S_PDEV: begin strobe.sendByte = 1'b1; strobe.txByte = devByte;     end
        S_AHI:         begin strobe.sendByte = 1'b1; strobe.txByte = addrQ[15:8]; end
        S_ALO:         begin strobe.sendByte = 1'b1; strobe.txByte = addrQ[7:0];  end
        S_DATA: if (dataValid) begin
          strobe.sendByte = 1'b1;
          strobe.txByte   = dataByte;
          dataReady       = 1'b1;
        end
        S_WSTOP, S_PSTOP, S_ESTOP, S_FSTOP: strobe.stop = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      launched   <= 1'b0;
      strapQ     <= 2'd0;
      addrQ      <= 16'd0;
      remQ       <= '0;
      pollCnt    <= '0;
      nackFlag   <= 1'b0;
      toFlag     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      errNack    <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      done       <= 1'b0;
      errNack    <= 1'b0;
      errTimeout <= 1'b0;
      if (launchNow) launched <= 1'b1;
      if (state == S_IDLE) begin
        if (cmdValid) begin
          strapQ   <= cmdStrap;
          addrQ    <= cmdAddr;
          remQ     <= cmdLen;
          nackFlag <= 1'b0;
          toFlag   <= 1'b0;
          busy     <= 1'b1;
          state    <= S_START;
        end
      end else if (opDone) begin
        launched <= 1'b0;
        case (state)
          S_START: state <= S_DEV;
          S_DEV, S_AHI, S_ALO: begin
            if (!ackSeen) begin
              nackFlag <= 1'b1;
              state    <= S_ESTOP;
            end else begin
              state <= (state == S_DEV) ? S_AHI : ((state == S_AHI) ? S_ALO : S_DATA);
            end
          end
          S_DATA: begin
            if (!ackSeen) begin
              nackFlag <= 1'b1;
              state    <= S_ESTOP;
            end else if (remQ == '0) begin
              state <= S_WSTOP;
            end else begin
              remQ <= remQ - 1'b1;
            end
          end
          S_WSTOP: begin
            pollCnt <= '0;
            state   <= S_PSTART;
          end
          S_PSTART: state <= S_PDEV;
          S_PDEV: begin
            if (ackSeen) begin
              state <= S_FSTOP;
            end else if (pollCnt == POLL_LAST) begin
              toFlag <= 1'b1;
              state  <= S_ESTOP;
            end else begin
              pollCnt <= pollCnt + 1'b1;
              state   <= S_PSTOP;
            end
          end
          S_PSTOP: state <= S_PSTART;
          S_ESTOP: begin
            errNack    <= nackFlag;
            errTimeout <= toFlag;
            busy       <= 1'b0;
            state      <= S_IDLE;
          end
          S_FSTOP: begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_ready_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !busy);

  assert_take_only_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> dataValid);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !errNack && !errTimeout));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int CLK_DIV    = 8,
  parameter int PAGE_BYTES = 64,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  output logic                          cmdReady,
  input  logic [1:0]                    cmdStrap,
  input  logic [15:0]                   cmdAddr,
  input  logic [$clog2(PAGE_BYTES)-1:0] cmdLen,
  input  logic                          dataValid,
  output logic                          dataReady,
  input  logic [7:0]                    dataByte,
  output logic                          busy,
  output logic                          done,
  output logic                          errNack,
  output logic                          errTimeout,
  output logic                          sclOut,
  output logic                          sdaOut,
  input  logic                          sdaIn
);

  strobe_t strobe;
  logic    opDone, ackSeen;

  epw_control #(.PAGE_BYTES(PAGE_BYTES), .POLL_LIMIT(POLL_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdStrap(cmdStrap),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
    .busy(busy), .done(done), .errNack(errNack), .errTimeout(errTimeout),
    .strobe(strobe), .opDone(opDone), .ackSeen(ackSeen)
  );

  epw_bitpath #(.CLK_DIV(CLK_DIV)) uBits (
    .clk(clk), .rstN(rstN), .cmd(strobe), .sdaIn(sdaIn),
    .opDone(opDone), .ackSeen(ackSeen), .sclOut(sclOut), .sdaOut(sdaOut)
  );

  // Every ending leaves the bus released
  assert_bus_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done || errNack || errTimeout) |-> (sclOut && sdaOut));

endmodule

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;

  localparam int DIV  = 2;
  localparam int PLIM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [1:0] cmdStrap = 2'd0;
  logic [15:0] cmdAddr = 16'd0;
  logic [5:0] cmdLen = 6'd0;
  logic dataValid = 1'b0;
  logic dataReady;
  logic [7:0] dataByte = 8'd0;
  logic busy, done, errNack, errTimeout, sclOut, sdaOut, sdaIn;
  logic slaveDrv = 1'b1;

  assign sdaIn = sdaOut & slaveDrv;

  always #4 clk = ~clk;

  eeprom_page_writer #(.CLK_DIV(DIV), .PAGE_BYTES(64), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdStrap(cmdStrap), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
    .busy(busy), .done(done), .errNack(errNack), .errTimeout(errTimeout),
    .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expDev(input logic [1:0] s);
    return {4'b1010, 1'b0, s, 1'b0};
  endfunction

  // ---------------- EEPROM model on the wires ----------------
  logic [1:0] slaveStrap = 2'b10;
  int armed = 0, busyCfg = 0, busyLeft = 0, nackAt = -1;
  int devCount = 0, startCount = 0, stopCount = 0, capCount = 0, hiBad = 0;
  logic [7:0] capDev = 8'd0, capHi = 8'd0, capLo = 8'd0;
  logic [7:0] capB [0:66];
  bit inFrame = 0, riseInFrame = 0, ack;
  int bitCnt = 0, byteIdx = 0, hiLen = 0;
  logic [7:0] sh = 8'd0;
  logic prevScl = 1'b1, prevSda = 1'b1, scl, sda;

  always @(negedge clk) begin
    if (rstN) begin
      scl = sclOut;
      sda = sdaIn;
      if (prevScl && scl && prevSda && !sda) begin
        inFrame = 1; bitCnt = 0; byteIdx = 0; startCount++;
      end else if (prevScl && scl && !prevSda && sda) begin
        inFrame = 0; stopCount++; riseInFrame = 0;
        if (armed != 0) begin armed = 0; busyLeft = busyCfg; end
      end else if (!prevScl && scl) begin
        riseInFrame = inFrame; hiLen = 1;
        if (inFrame && bitCnt < 8) begin sh = {sh[6:0], sda}; bitCnt++; end
      end else if (prevScl && !scl) begin
        if (riseInFrame && hiLen != 2*DIV) hiBad++;
        riseInFrame = 0;
        if (inFrame && bitCnt == 8) begin
          ack = 1;
          if (byteIdx == 0) begin
            devCount++;
            if (armed != 0) capDev = sh;
            if (sh != expDev(slaveStrap)) ack = 0;
            else if (armed == 0 && busyLeft > 0) begin ack = 0; busyLeft--; end
          end else if (armed != 0) begin
            if (byteIdx == 1) capHi = sh;
            else if (byteIdx == 2) capLo = sh;
            else if (capCount < 67) begin capB[capCount] = sh; capCount++; end
          end
          if (armed != 0 && byteIdx == nackAt) ack = 0;
          slaveDrv = ack ? 1'b0 : 1'b1;
          bitCnt = 9;
        end else if (inFrame && bitCnt == 9) begin
          slaveDrv = 1'b1; bitCnt = 0; byteIdx++;
        end
      end else if (scl) begin
        hiLen++;
      end
      prevScl = scl;
      prevSda = sdaOut & slaveDrv;
    end
  end

  // ---------------- data stream source ----------------
  logic [7:0] dataVec [0:63];
  int feedIdx = 0, feedN = 0;
  bit took = 0, feedReset = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (feedReset) begin
        feedIdx = 0; took = 0; dataValid = 1'b0; feedReset = 0;
      end
      if (took) begin feedIdx++; took = 0; dataValid = 1'b0; end
      if (!dataValid && feedIdx < feedN && ($urandom % 3 != 0)) begin
        dataValid = 1'b1; dataByte = dataVec[feedIdx];
      end
      #1;
      if (dataValid && dataReady) took = 1;
    end
  end

  // ---------------- one transaction ----------------
  // kind: 0 = expect done, 1 = expect errNack, 2 = expect errTimeout
  task automatic runTx(input logic [1:0] strap, input logic [15:0] addr,
                       input logic [5:0] len, input int busyN, input int nackIdx,
                       input int kind);
    int n, mism, busyDrop;
    bit gotDone, gotNack, gotTo;
    n = int'(len) + 1;
    for (int i = 0; i < 64; i++) dataVec[i] = 8'($urandom);
    feedN = n; feedReset = 1;
    armed = 1; busyCfg = busyN; busyLeft = 0; nackAt = nackIdx;
    devCount = 0; startCount = 0; stopCount = 0; capCount = 0; hiBad = 0;
    repeat (2) @(negedge clk);
    cmdStrap = strap; cmdAddr = addr; cmdLen = len; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1 && cmdReady === 1'b0, "R9", "busy after accept", int'(busy), 1);
    busyDrop = 0;
    gotDone = 0; gotNack = 0; gotTo = 0;
    while (!(gotDone || gotNack || gotTo)) begin
      @(negedge clk);
      gotDone = done; gotNack = errNack; gotTo = errTimeout;
      if (!busy && !(gotDone || gotNack || gotTo)) busyDrop++;
    end
    check(busyDrop == 0 && !busy && cmdReady, "R9", "busy span", busyDrop, 0);
    check(sclOut && sdaOut, "R5", "bus released at end", int'({sclOut, sdaOut}), 3);
    check(stopCount == startCount, "R5", "stops per start", stopCount, startCount);
    check(startCount == devCount, "R10", "start conditions per frame", startCount, devCount);
    check(hiBad == 0, "R11", "scl high width errors", hiBad, 0);
    if (kind == 0) begin
      check(gotDone && !gotNack && !gotTo, "R6", "done pulse", int'(gotDone), 1);
      check(capDev == expDev(strap), "R2", "device byte", int'(capDev), int'(expDev(strap)));
      check({capHi, capLo} == addr, "R3", "address bytes", int'({capHi, capLo}), int'(addr));
      check(capCount == n, "R4", "data byte count", capCount, n);
      mism = 0;
      for (int i = 0; i < n && i < capCount; i++) if (capB[i] != dataVec[i]) mism++;
      check(mism == 0, "R4", "data byte mismatches", mism, 0);
      check(devCount - 1 == busyN + 1, "R6", "probe count", devCount - 1, busyN + 1);
    end else if (kind == 1) begin
      check(gotNack && !gotDone && !gotTo, "R7", "errNack pulse", int'(gotNack), 1);
      check(devCount == 1, "R7", "no probes after abort", devCount - 1, 0);
    end else begin
      check(gotTo && !gotDone && !gotNack, "R8", "errTimeout pulse", int'(gotTo), 1);
      check(devCount - 1 == PLIM, "R8", "probes before timeout", devCount - 1, PLIM);
    end
    @(negedge clk);
    check(!done && !errNack && !errTimeout, "R9", "end pulse one cycle",
          int'({done, errNack, errTimeout}), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOut && sdaOut, "R1", "bus idle after reset", int'({sclOut, sdaOut}), 3);
    check(!busy && cmdReady, "R1", "idle handshake after reset", int'({busy, cmdReady}), 1);
    check(!done && !errNack && !errTimeout, "R1", "no pulses after reset",
          int'({done, errNack, errTimeout}), 0);

    // single byte, device ready at first probe
    runTx(slaveStrap, 16'h1234, 6'd0, 0, -1, 0);
    // full page with busy device
    runTx(slaveStrap, 16'hABC0, 6'd63, 3, -1, 0);
    // strap mismatch: device select refused
    runTx(2'b01, 16'h0040, 6'd3, 0, -1, 1);
    // refusals at address high, address low, third data byte
    runTx(slaveStrap, 16'h0100, 6'd4, 0, 1, 1);
    runTx(slaveStrap, 16'h0200, 6'd4, 0, 2, 1);
    runTx(slaveStrap, 16'h0300, 6'd4, 0, 5, 1);
    // probe limit boundary
    runTx(slaveStrap, 16'h7F00, 6'd2, PLIM - 1, -1, 0);
    runTx(slaveStrap, 16'h7F40, 6'd2, PLIM, -1, 2);

    // random mix
    for (int t = 0; t < 8; t++) begin
      runTx(slaveStrap, 16'($urandom), 6'($urandom % 64), int'($urandom % PLIM), -1, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule